// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block gathers message-signalled interrupts, which arrive as memory writes, and merges them into one level interrupt for a system interrupt controller. Every implemented vector has its own 32-bit doorbell word on a doorbell slave port. A well-formed write to a doorbell marks that vector pending. Reading the same doorbell word returns the pending state and clears it, so a service routine acknowledges each vector by touching its own doorbell.

A second slave port holds three control/status words: a read-only pending view, a sticky error word that software clears by writing ones, and an enable mask. The interrupt output stays high while any pending vector is also enabled. The vector count is a build parameter of at most 32. Both ports use single-cycle read and write strobes, and read data is returned on the cycle after the strobe.

Top module: `msi_doorbell_agg`

## Requirements
- R1: After a synchronous active-low reset, the pending, mask and error words all read 0, and `irq_out` is low.
- R2: A doorbell write with byte address 4·n (index = `db_addr[DB_AW-1:2]`, bits [1:0] ignored) and data exactly n, where n < NUM_VEC, sets pending bit n. The pending word at CSR offset 0x0 shows vector n in bit n.
- R3: `irq_out` is high exactly when some vector is both pending and enabled (mask word at CSR offset 0x8, bit n = 1 enables vector n). A masked vector still shows as pending but does not drive the output.
- R4: A doorbell read of vector n returns the pending state of n in bit 0 (upper bits 0) on the cycle after the strobe, and clears pending bit n.
- R5: When a valid doorbell write and a doorbell read hit the same vector in the same cycle, the vector is pending afterwards. The read returns the state from before that cycle.
- R6: A doorbell write with index ≥ NUM_VEC sets error bit 0 (range). A write with a valid index whose data differs from the index sets error bit 1 (data). Neither write sets any pending bit.
- R7: The error word at CSR offset 0x4 is sticky. Writing 1 to a bit clears it. A new error in the same cycle as the clear leaves the bit set.
- R8: The pending word is read-only: CSR writes to offset 0x0 change nothing.
- R9: Bits at or above NUM_VEC read 0 in the pending and mask words, and mask writes to those bits are ignored. A doorbell read with index ≥ NUM_VEC returns 0.
- R10: Reading the pending word does not clear it. Vectors that arrive while others are being serviced stay visible on later reads, until their own doorbell is read.
- R11: CSR read data appears on the cycle after the read strobe. Unmapped offsets read 0, and both read-data outputs are 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_rd | input | 1 | Doorbell read strobe |
| db_addr | input | DB_AW | Doorbell byte address |
| db_wdata | input | 32 | Doorbell write data (message payload) |
| db_rdata | output | 32 | Doorbell read data, bit 0 = pending before the read |
| csr_wr | input | 1 | CSR write strobe |
| csr_rd | input | 1 | CSR read strobe |
| csr_addr | input | 4 | CSR byte offset |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| irq_out | output | 1 | Aggregated level interrupt |

## Verification
The bench targets a write and a clearing read that meet on one vector in the same cycle. A design that let the read win would drop the message, so the pending word would come back zero after the collision. It also checks that an error clear and a fresh error in the same cycle leave the error bit set, and that a status write or a mask write above the vector count leaves no trace. A design that cleared pending bits when the status word was read would lose the vector that arrived during servicing. A design that decoded only part of the address or ignored the payload check would set pending bits for messages that should be rejected.

// File: rtl/msi_agg_pkg.sv
// Shared constants for the MSI doorbell aggregator: CSR byte offsets and
// error-word bit positions. Assumes a 4-bit CSR byte address.
package msi_agg_pkg;
    localparam logic [3:0] CSR_PENDING = 4'h0;
    localparam logic [3:0] CSR_ERRORS  = 4'h4;
    localparam logic [3:0] CSR_ENABLES = 4'h8;

    localparam int ERR_RANGE_BIT = 0;
    localparam int ERR_DATA_BIT  = 1;
    localparam int ERR_W         = 2;
endpackage

// File: rtl/msi_db_decode.sv
// Doorbell access decoder. Turns a doorbell-port access into one-hot set and
// clear requests plus error flags. Purely combinational. Assumes the index
// field db_addr[DB_AW-1:2] can address every implemented vector.
module msi_db_decode #(
    parameter int NUM_VEC = 20,
    parameter int DB_AW   = 7
) (
    input  logic               db_wr,
    input  logic               db_rd,
    input  logic [DB_AW-1:0]   db_addr,
    input  logic [31:0]        db_wdata,
    output logic [NUM_VEC-1:0] set_vec,
    output logic [NUM_VEC-1:0] clr_vec,
    output logic               rd_ok,
    output logic [DB_AW-3:0]   rd_idx,
    output logic               bad_range,
    output logic               bad_data
);
    localparam int IDX_W = DB_AW - 2;

    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             data_ok;
    logic             unused_addr;

    // Extract the word index and qualify it against the configured count.
    always_comb begin
        idx         = db_addr[DB_AW-1:2];
        in_range    = 32'(idx) < 32'(NUM_VEC);
        data_ok     = db_wdata == 32'(idx);
        unused_addr = &{1'b0, db_addr[1:0]};
    end

    // Error flags for rejected doorbell writes; range error takes precedence.
    always_comb begin
        bad_range = db_wr && !in_range;
        bad_data  = db_wr && in_range && !data_ok;
        rd_ok     = db_rd && in_range;
        rd_idx    = idx;
    end

    genvar v;
    generate
        for (v = 0; v < NUM_VEC; v++) begin : g_vec
            // Per-vector set and clear requests.
            assign set_vec[v] = db_wr && data_ok && (idx == IDX_W'(v));
            assign clr_vec[v] = db_rd && (idx == IDX_W'(v));
        end
    endgenerate
endmodule

// File: rtl/msi_pend_bank.sv
// Pending-bit storage with doorbell read-back. Sets win over clears in the
// same cycle so no message is lost. Read data is registered and is zero in
// any cycle that follows no valid doorbell read.
module msi_pend_bank #(
    parameter int NUM_VEC = 20,
    parameter int DB_AW   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_vec,
    input  logic [NUM_VEC-1:0] clr_vec,
    input  logic               rd_ok,
    input  logic [DB_AW-3:0]   rd_idx,
    output logic [NUM_VEC-1:0] pend_q,
    output logic [31:0]        rd_data
);
    localparam int SPAN = 1 << (DB_AW - 2);

    logic [SPAN-1:0] pend_ext;

    // Widen pending bits to the full index span for safe indexing.
    always_comb pend_ext = SPAN'(pend_q);

    // Pending register: clear requested bits, then apply sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // Doorbell read data: pending state before this cycle's update.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_ok) rd_data <= {31'b0, pend_ext[rd_idx]};
        else            rd_data <= '0;
    end
endmodule

// File: rtl/msi_csr_block.sv
// Control/status registers: read-only pending view, sticky W1C error word,
// and per-vector enable mask. Read data is registered one cycle after the
// strobe. Assumes NUM_VEC <= 32.
module msi_csr_block
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr,
    input  logic               csr_rd,
    input  logic [3:0]         csr_addr,
    input  logic [31:0]        csr_wdata,
    input  logic [NUM_VEC-1:0] pend_q,
    input  logic               bad_range,
    input  logic               bad_data,
    output logic [NUM_VEC-1:0] mask_q,
    output logic [ERR_W-1:0]   err_q,
    output logic [31:0]        csr_rdata
);
    logic [ERR_W-1:0] err_clr;
    logic [ERR_W-1:0] err_set;
    logic             unused_wdata;

    // Build the error clear and set vectors for this cycle.
    always_comb begin
        err_clr = (csr_wr && csr_addr == CSR_ERRORS) ? csr_wdata[ERR_W-1:0] : '0;
        err_set = '0;
        err_set[ERR_RANGE_BIT] = bad_range;
        err_set[ERR_DATA_BIT]  = bad_data;
        unused_wdata = &{1'b0, csr_wdata};
    end

    // Enable mask: only implemented vector bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_q <= '0;
        else if (csr_wr && csr_addr == CSR_ENABLES) mask_q <= csr_wdata[NUM_VEC-1:0];
    end

    // Sticky error word; a new error outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_set;
    end

    // Registered read mux; unmapped offsets and idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_rdata <= '0;
        end else if (csr_rd) begin
            case (csr_addr)
                CSR_PENDING: csr_rdata <= 32'(pend_q);
                CSR_ERRORS:  csr_rdata <= 32'(err_q);
                CSR_ENABLES: csr_rdata <= 32'(mask_q);
                default:     csr_rdata <= '0;
            endcase
        end else begin
            csr_rdata <= '0;
        end
    end
endmodule

// File: rtl/msi_doorbell_agg.sv
// Top of the MSI doorbell aggregator. Joins the doorbell decoder, pending
// bank and CSR block, and drives one level interrupt from enabled pending
// vectors. Assumes 1 <= NUM_VEC <= 32 and 2**(DB_AW-2) >= NUM_VEC.
module msi_doorbell_agg
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 20,
    parameter int DB_AW   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_wr,
    input  logic             db_rd,
    input  logic [DB_AW-1:0] db_addr,
    input  logic [31:0]      db_wdata,
    output logic [31:0]      db_rdata,
    input  logic             csr_wr,
    input  logic             csr_rd,
    input  logic [3:0]       csr_addr,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    output logic             irq_out
);
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] clr_vec;
    logic               rd_ok;
    logic [DB_AW-3:0]   rd_idx;
    logic               bad_range;
    logic               bad_data;
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] mask_q;
    logic [ERR_W-1:0]   err_q;

    msi_db_decode #(.NUM_VEC(NUM_VEC), .DB_AW(DB_AW)) dec_i (
        .db_wr    (db_wr),
        .db_rd    (db_rd),
        .db_addr  (db_addr),
        .db_wdata (db_wdata),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .rd_ok    (rd_ok),
        .rd_idx   (rd_idx),
        .bad_range(bad_range),
        .bad_data (bad_data)
    );

    msi_pend_bank #(.NUM_VEC(NUM_VEC), .DB_AW(DB_AW)) pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .rd_ok  (rd_ok),
        .rd_idx (rd_idx),
        .pend_q (pend_q),
        .rd_data(db_rdata)
    );

    msi_csr_block #(.NUM_VEC(NUM_VEC)) csr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (csr_wr),
        .csr_rd   (csr_rd),
        .csr_addr (csr_addr),
        .csr_wdata(csr_wdata),
        .pend_q   (pend_q),
        .bad_range(bad_range),
        .bad_data (bad_data),
        .mask_q   (mask_q),
        .err_q    (err_q),
        .csr_rdata(csr_rdata)
    );

    // Aggregated level interrupt from enabled pending vectors.
    always_comb irq_out = |(pend_q & mask_q);
endmodule

// File: rtl/msi_agg_chk.sv
// Assertion checker for the MSI doorbell aggregator, bound to the top.
// Observes ports and the pending, mask and error registers.
module msi_agg_chk
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 20,
    parameter int DB_AW   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               db_wr,
    input logic               db_rd,
    input logic [DB_AW-1:0]   db_addr,
    input logic [31:0]        db_wdata,
    input logic               csr_wr,
    input logic [3:0]         csr_addr,
    input logic [31:0]        csr_wdata,
    input logic [NUM_VEC-1:0] pend_q,
    input logic [NUM_VEC-1:0] mask_q,
    input logic [ERR_W-1:0]   err_q,
    input logic               irq_out
);
    localparam int SPAN = 1 << (DB_AW - 2);

    logic [DB_AW-3:0] idx;
    logic             in_rng;
    logic             good_msg;
    logic [SPAN-1:0]  pend_ext;
    logic             unused_chk;

    // Independent view of the doorbell index and message validity.
    always_comb begin
        idx        = db_addr[DB_AW-1:2];
        in_rng     = 32'(idx) < 32'(NUM_VEC);
        good_msg   = in_rng && (db_wdata == 32'(idx));
        pend_ext   = SPAN'(pend_q);
        unused_chk = &{1'b0, db_addr[1:0], csr_wdata};
    end

    // R1: registers come out of reset cleared.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_q == '0 && mask_q == '0 && err_q == '0));

    // R2: a well-formed doorbell write leaves its vector pending.
    a_r2_db_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr && good_msg) |=> pend_ext[$past(idx)]);

    // R3: nothing enabled means the interrupt stays low.
    a_r3_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);

    // R3: the interrupt needs at least one pending vector.
    a_r3_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pend_q != '0));

    // R4: a doorbell read without a write clears its vector.
    a_r4_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (db_rd && in_rng && !db_wr) |=> !pend_ext[$past(idx)]);

    // R5: a write colliding with a clearing read keeps the vector pending.
    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (db_rd && db_wr && good_msg) |=> pend_ext[$past(idx)]);

    // R6: an out-of-range doorbell write raises the range error.
    a_r6_range_err: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr && !in_rng) |=> err_q[ERR_RANGE_BIT]);

    // R7: the range error holds until software writes one to it.
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[ERR_RANGE_BIT] && !(csr_wr && csr_addr == CSR_ERRORS && csr_wdata[ERR_RANGE_BIT]))
        |=> err_q[ERR_RANGE_BIT]);

    // R8: pending bits do not move without doorbell traffic.
    a_r8_pend_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!db_wr && !db_rd) |=> $stable(pend_q));
endmodule

bind msi_doorbell_agg msi_agg_chk #(.NUM_VEC(NUM_VEC), .DB_AW(DB_AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .db_wr    (db_wr),
    .db_rd    (db_rd),
    .db_addr  (db_addr),
    .db_wdata (db_wdata),
    .csr_wr   (csr_wr),
    .csr_addr (csr_addr),
    .csr_wdata(csr_wdata),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .err_q    (err_q),
    .irq_out  (irq_out)
);

// File: tb/msi_doorbell_agg_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the MSI doorbell aggregator: one task per scenario.
module msi_doorbell_agg_tb_top;
    localparam int NUM_VEC = 20;
    localparam int DB_AW   = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             db_wr = 1'b0;
    logic             db_rd = 1'b0;
    logic [DB_AW-1:0] db_addr = '0;
    logic [31:0]      db_wdata = '0;
    logic [31:0]      db_rdata;
    logic             csr_wr = 1'b0;
    logic             csr_rd = 1'b0;
    logic [3:0]       csr_addr = '0;
    logic [31:0]      csr_wdata = '0;
    logic [31:0]      csr_rdata;
    logic             irq_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    msi_doorbell_agg #(.NUM_VEC(NUM_VEC), .DB_AW(DB_AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .db_wr(db_wr), .db_rd(db_rd), .db_addr(db_addr),
        .db_wdata(db_wdata), .db_rdata(db_rdata),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic db_write(input int idx, input logic [31:0] data);
        @(negedge clk);
        db_wr = 1'b1; db_addr = DB_AW'(idx * 4); db_wdata = data;
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic db_read(input int idx, output logic [31:0] rd);
        @(negedge clk);
        db_rd = 1'b1; db_addr = DB_AW'(idx * 4);
        @(negedge clk);
        db_rd = 1'b0;
        rd = db_rdata;
    endtask

    task automatic csr_write(input logic [3:0] off, input logic [31:0] data);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = off; csr_wdata = data;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [3:0] off, output logic [31:0] rd);
        @(negedge clk);
        csr_rd = 1'b1; csr_addr = off;
        @(negedge clk);
        csr_rd = 1'b0;
        rd = csr_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        csr_read(4'h0, v); check("R1 pending after reset", v, 32'h0);
        csr_read(4'h8, v); check("R1 mask after reset", v, 32'h0);
        csr_read(4'h4, v); check("R1 error after reset", v, 32'h0);
        check("R1 irq after reset", 32'(irq_out), 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] v;
        db_write(3, 32'd3);
        db_write(19, 32'd19);
        csr_read(4'h0, v); check("R2 pending after writes 3,19", v, (32'h1 << 3) | (32'h1 << 19));
        check("R3 masked pending keeps irq low", 32'(irq_out), 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        csr_write(4'h8, 32'h1 << 19);
        check("R3 enabled pending raises irq", 32'(irq_out), 32'h1);
        csr_write(4'h8, 32'hFFFF_FFFF);
        csr_read(4'h8, v); check("R9 mask upper bits read zero", v, 32'h000F_FFFF);
        csr_write(4'h8, 32'h1 << 19);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        db_read(3, v); check("R4 doorbell read returns pending", v, 32'h1);
        csr_read(4'h0, v); check("R4 vector 3 cleared", v, 32'h1 << 19);
        db_read(3, v); check("R4 second read returns zero", v, 32'h0);
        check("R3 irq still high for vector 19", 32'(irq_out), 32'h1);
        db_read(19, v); check("R4 doorbell 19 returns pending", v, 32'h1);
        check("R3 irq drops after clear", 32'(irq_out), 32'h0);
        csr_write(4'h8, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        db_write(6, 32'd6);
        @(negedge clk);
        db_wr = 1'b1; db_rd = 1'b1; db_addr = DB_AW'(24); db_wdata = 32'd6;
        @(negedge clk);
        db_wr = 1'b0; db_rd = 1'b0;
        check("R5 collision read returns prior state", db_rdata, 32'h1);
        csr_read(4'h0, v); check("R5 vector stays pending after collision", v, 32'h1 << 6);
        db_read(6, v);
        @(negedge clk);
        db_wr = 1'b1; db_rd = 1'b1; db_addr = DB_AW'(24); db_wdata = 32'd6;
        @(negedge clk);
        db_wr = 1'b0; db_rd = 1'b0;
        check("R5 collision on idle vector reads zero", db_rdata, 32'h0);
        csr_read(4'h0, v); check("R5 idle vector set by collision", v, 32'h1 << 6);
        db_read(6, v);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        db_write(25, 32'd25);
        csr_read(4'h4, v); check("R6 range error bit", v, 32'h1);
        db_write(7, 32'd9);
        csr_read(4'h4, v); check("R6 data error bit", v, 32'h3);
        csr_read(4'h0, v); check("R6 rejected writes set nothing", v, 32'h0);
        db_read(25, v); check("R9 out-of-range doorbell reads zero", v, 32'h0);
    endtask

    task automatic t_err_clear();
        logic [31:0] v;
        csr_write(4'h4, 32'h1);
        csr_read(4'h4, v); check("R7 W1C clears range bit only", v, 32'h2);
        csr_write(4'h4, 32'h2);
        csr_read(4'h4, v); check("R7 W1C clears data bit", v, 32'h0);
        db_write(25, 32'd25);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = 4'h4; csr_wdata = 32'h1;
        db_wr = 1'b1; db_addr = DB_AW'(25 * 4); db_wdata = 32'd25;
        @(negedge clk);
        csr_wr = 1'b0; db_wr = 1'b0;
        csr_read(4'h4, v); check("R7 new error beats same-cycle clear", v, 32'h1);
        csr_write(4'h4, 32'h3);
        csr_read(4'h4, v); check("R7 error word clear", v, 32'h0);
    endtask

    task automatic t_status_ro();
        logic [31:0] v;
        db_write(1, 32'd1);
        csr_write(4'h0, 32'h0);
        csr_read(4'h0, v); check("R8 zero write to pending ignored", v, 32'h2);
        csr_write(4'h0, 32'hFFFF_FFFF);
        csr_read(4'h0, v); check("R8 ones write to pending ignored", v, 32'h2);
        db_read(1, v);
    endtask

    task automatic t_service();
        logic [31:0] v;
        db_write(2, 32'd2);
        db_write(5, 32'd5);
        csr_read(4'h0, v); check("R10 first service read", v, 32'h24);
        db_read(2, v);
        db_write(7, 32'd7);
        csr_read(4'h0, v); check("R10 late arrival visible", v, 32'hA0);
        csr_read(4'h0, v); check("R10 status read does not clear", v, 32'hA0);
        db_read(5, v);
        db_read(7, v);
        csr_read(4'h0, v); check("R10 loop ends at zero", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        csr_write(4'h8, 32'h5);
        csr_read(4'hC, v); check("R11 unmapped offset reads zero", v, 32'h0);
        @(negedge clk);
        check("R11 csr read data idle zero", csr_rdata, 32'h0);
        check("R11 doorbell read data idle zero", db_rdata, 32'h0);
        csr_read(4'h8, v); check("R11 mask read one cycle after strobe", v, 32'h5);
        csr_write(4'h8, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_mask();
        t_clear();
        t_collision();
        t_errors();
        t_err_clear();
        t_status_ro();
        t_service();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule